// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from up to 27 peripherals and presents the CPU with one request line and a byte vector address. Each peripheral owns a control register that holds a pending flag, an enable bit and a 4-bit priority level. Among the sources that are flagged, enabled and above the CPU's current priority, the controller picks the highest level, breaking ties towards the lowest source index. It converts that source's trap number into a jump-table address by multiplying the number by four.

Two trap paths sit above the peripheral interrupts. A software trap carries its own 7-bit trap number. A group of hardware exception inputs shares one common vector, and each input leaves a sticky bit in a trap flag register so that the handler can tell the causes apart. A small register port reads and writes the control registers and the trap flag register. The chosen request and vector are held unchanged until the CPU acknowledges them.

Top module: `prio_vector_intc`

## Requirements
- R1: Control register n sits at register address n and reads back with the pending flag in bit 7, the enable in bit 6 and the priority in bits 3:0. All other bits read as 0. A one-cycle pulse on a source's strobe input sets its pending flag.
- R2: The vector is the trap number shifted left by 2, zero-extended to 16 bits. Source 0 uses trap number 0x17, source 1 uses 0x21, source 2 uses 0x20 and source 3 uses 0x29. Every other source n uses 0x30+n.
- R3: A source can request only if its priority is strictly greater than `cpu_prio`. A source at priority 0 therefore never requests.
- R4: Of the eligible sources, the one with the highest priority is granted. Among equal priorities, the lowest index is granted.
- R5: `int_req` and `int_vec` stay constant from the cycle they are raised until an acknowledge. An acknowledge drops `int_req` on the next cycle and clears the granted source's pending flag. The next grant appears one cycle after that.
- R6: A strobe from the granted source in the same cycle as its acknowledge leaves the pending flag set, so the source is requested again.
- R7: A source whose enable is 0 still records its pending flag but never raises `int_req`.
- R8: A register write sets or clears the pending flag, the enable and the priority of the addressed source.
- R9: A software trap request with a 7-bit trap number is granted with vector number<<2. While one software trap is pending, further software trap requests are ignored.
- R10: A pulse on any exception input sets the matching bit of the trap flag register, which reads at address 0x7F in bits 3:0. It also requests the common vector 0x0028, which is trap number 0x0A.
- R11: A trap flag bit stays set through acknowledges. It clears only when a register write to 0x7F carries 0 in that bit position. Writing 1 leaves the bit unchanged.
- R12: When several kinds of request are waiting, they are granted in this order: exception trap first, then software trap, then peripheral interrupts.
- R13: After reset, `int_req` is 0 and every control register and the trap flag register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_strobe | input | 27 | One-cycle request strobe per peripheral source |
| cpu_prio | input | 4 | Current CPU priority level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (source index, or 0x7F for trap flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| sw_trap_req | input | 1 | Software trap request pulse |
| sw_trap_num | input | 7 | Software trap number |
| exc_in | input | 4 | Hardware exception cause pulses |
| int_ack | input | 1 | CPU acknowledge of the presented request |
| int_req | output | 1 | Request to the CPU |
| int_vec | output | 16 | Vector byte address of the presented request |

## Verification
An acknowledge and a new strobe from the same peripheral can arrive in the same cycle. The bench provokes this by holding the acknowledge of a granted source while pulsing that source's strobe. It then judges the result in three ways: the pending flag reads back as still set, `int_req` drops for one cycle, and the same vector is granted a second time. All three request kinds can also become pending in one cycle. That is provoked with a single simultaneous pulse, and the scoreboard judges it by the order in which the exception, software and peripheral vectors come out.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 16;
  localparam int TRAP_W = 7;
  localparam int PEND_BIT = 7;
  localparam int ENA_BIT  = 6;

  typedef enum logic [1:0] {GK_NONE, GK_EXC, GK_SW, GK_IRQ} gnt_kind_e;

  function automatic logic [TRAP_W-1:0] src_trap_num(input int idx);
    case (idx)
      0:       return 7'h17;
      1:       return 7'h21;
      2:       return 7'h20;
      3:       return 7'h29;
      default: return 7'h30 + TRAP_W'(idx);
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] trap_to_vec(input logic [TRAP_W-1:0] num);
    return {{(VEC_W-TRAP_W-2){1'b0}}, num, 2'b00};
  endfunction
endpackage

// File: rtl/intc_src_reg.sv
module intc_src_reg #(
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe,
  input  logic                     ack_clr,
  input  logic                     wr_en,
  input  logic [intc_pkg::DATA_W-1:0] wdata,
  output logic                     pend,
  output logic                     ena,
  output logic [PRIO_W-1:0]        prio
);
  logic              pend_d, ena_d;
  logic [PRIO_W-1:0] prio_d;

  // Strobe beats acknowledge, acknowledge beats a software write.
  always_comb begin
    pend_d = pend;
    ena_d  = ena;
    prio_d = prio;
    if (wr_en) begin
      pend_d = wdata[intc_pkg::PEND_BIT];
      ena_d  = wdata[intc_pkg::ENA_BIT];
      prio_d = wdata[PRIO_W-1:0];
    end
    if (ack_clr) pend_d = 1'b0;
    if (strobe)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ena  <= 1'b0;
      prio <= '0;
    end else begin
      pend <= pend_d;
      ena  <= ena_d;
      prio <= prio_d;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 27,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_vec,
  input  logic [NUM_SRC-1:0]        ena_vec,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         cpu_prio,
  output logic                      any,
  output logic [IDX_W-1:0]          win_idx
);
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] lvl;

  // Strict compare keeps the lowest index on ties.
  always_comb begin
    any     = 1'b0;
    best    = '0;
    win_idx = '0;
    lvl     = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl = prio_flat[i*PRIO_W +: PRIO_W];
      if (pend_vec[i] && ena_vec[i] && (lvl > cpu_prio) && (!any || lvl > best)) begin
        any     = 1'b1;
        best    = lvl;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_trap_unit.sv
module intc_trap_unit #(
  parameter int NUM_EXC = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_EXC-1:0]          exc_in,
  input  logic                        sw_req,
  input  logic [intc_pkg::TRAP_W-1:0] sw_num,
  input  logic                        flag_wr,
  input  logic [NUM_EXC-1:0]          flag_wdata,
  input  logic                        ack_exc,
  input  logic                        ack_sw,
  output logic                        exc_pend,
  output logic                        sw_pend,
  output logic [intc_pkg::TRAP_W-1:0] sw_num_q,
  output logic [NUM_EXC-1:0]          flags
);
  logic [NUM_EXC-1:0] flags_d;
  logic               exc_pend_d, sw_pend_d, sw_load;

  always_comb begin
    flags_d = flags;
    if (flag_wr) flags_d = flags & flag_wdata;
    flags_d = flags_d | exc_in;

    exc_pend_d = exc_pend;
    if (ack_exc)  exc_pend_d = 1'b0;
    if (|exc_in)  exc_pend_d = 1'b1;

    sw_load   = sw_req && !sw_pend;
    sw_pend_d = sw_pend;
    if (ack_sw)       sw_pend_d = 1'b0;
    else if (sw_load) sw_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      exc_pend <= 1'b0;
      sw_pend  <= 1'b0;
      sw_num_q <= '0;
    end else begin
      flags    <= flags_d;
      exc_pend <= exc_pend_d;
      sw_pend  <= sw_pend_d;
      if (sw_load) sw_num_q <= sw_num;
    end
  end
endmodule

// File: rtl/prio_vector_intc.sv
module prio_vector_intc #(
  parameter int NUM_SRC  = 27,
  parameter int PRIO_W   = 4,
  parameter int NUM_EXC  = 4,
  parameter int REG_AW   = 7,
  parameter logic [REG_AW-1:0] FLAG_ADDR = 7'h7F,
  parameter logic [6:0] EXC_TRAP = 7'h0A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          irq_strobe,
  input  logic [PRIO_W-1:0]           cpu_prio,
  input  logic                        reg_wr,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [intc_pkg::DATA_W-1:0] reg_wdata,
  output logic [intc_pkg::DATA_W-1:0] reg_rdata,
  input  logic                        sw_trap_req,
  input  logic [intc_pkg::TRAP_W-1:0] sw_trap_num,
  input  logic [NUM_EXC-1:0]          exc_in,
  input  logic                        int_ack,
  output logic                        int_req,
  output logic [intc_pkg::VEC_W-1:0]  int_vec
);
  import intc_pkg::*;
  localparam int IDX_W = $clog2(NUM_SRC);

  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  logic [NUM_SRC-1:0]        pend_vec, ena_vec, src_wr, ack_clr;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      irq_any;
  logic [IDX_W-1:0]          win_idx;
  logic                      exc_pend, sw_pend;
  logic [TRAP_W-1:0]         sw_num_q;
  logic [NUM_EXC-1:0]        tfr_q;

  gnt_kind_e         kind_q, kind_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              req_d;
  logic [VEC_W-1:0]  vec_d;
  logic              ack_fire;

  assign ack_fire = int_ack && int_req;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      src_wr[i]  = reg_wr && (reg_addr == REG_AW'(i));
      ack_clr[i] = ack_fire && (kind_q == GK_IRQ) && (idx_q == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    intc_src_reg #(.PRIO_W(PRIO_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .strobe  (irq_strobe[g]),
      .ack_clr (ack_clr[g]),
      .wr_en   (src_wr[g]),
      .wdata   (reg_wdata),
      .pend    (pend_vec[g]),
      .ena     (ena_vec[g]),
      .prio    (prio_flat[g*PRIO_W +: PRIO_W])
    );
  end

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_vec  (pend_vec),
    .ena_vec   (ena_vec),
    .prio_flat (prio_flat),
    .cpu_prio  (cpu_prio),
    .any       (irq_any),
    .win_idx   (win_idx)
  );

  intc_trap_unit #(.NUM_EXC(NUM_EXC)) u_trap (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .exc_in     (exc_in),
    .sw_req     (sw_trap_req),
    .sw_num     (sw_trap_num),
    .flag_wr    (reg_wr && (reg_addr == FLAG_ADDR)),
    .flag_wdata (reg_wdata[NUM_EXC-1:0]),
    .ack_exc    (ack_fire && (kind_q == GK_EXC)),
    .ack_sw     (ack_fire && (kind_q == GK_SW)),
    .exc_pend   (exc_pend),
    .sw_pend    (sw_pend),
    .sw_num_q   (sw_num_q),
    .flags      (tfr_q)
  );

  // Grant selection: exception, then software trap, then peripherals.
  always_comb begin
    req_d  = int_req;
    vec_d  = int_vec;
    kind_d = kind_q;
    idx_d  = idx_q;
    if (ack_fire) begin
      req_d  = 1'b0;
      kind_d = GK_NONE;
    end else if (!int_req) begin
      if (exc_pend) begin
        req_d  = 1'b1;
        kind_d = GK_EXC;
        vec_d  = trap_to_vec(EXC_TRAP);
      end else if (sw_pend) begin
        req_d  = 1'b1;
        kind_d = GK_SW;
        vec_d  = trap_to_vec(sw_num_q);
      end else if (irq_any) begin
        req_d  = 1'b1;
        kind_d = GK_IRQ;
        idx_d  = win_idx;
        vec_d  = trap_to_vec(src_trap_num(int'(win_idx)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      int_req <= 1'b0;
      int_vec <= '0;
      kind_q  <= GK_NONE;
      idx_q   <= '0;
    end else begin
      int_req <= req_d;
      int_vec <= vec_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == FLAG_ADDR) begin
      reg_rdata = DATA_W'(tfr_q);
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reg_addr == REG_AW'(i))
          reg_rdata = {pend_vec[i], ena_vec[i], {(DATA_W-2-PRIO_W){1'b0}},
                       prio_flat[i*PRIO_W +: PRIO_W]};
      end
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_EXC = 4,
  parameter int REG_AW  = 7,
  parameter logic [REG_AW-1:0] FLAG_ADDR = 7'h7F
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_req,
  input logic               int_ack,
  input logic [15:0]        int_vec,
  input logic               reg_wr,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [NUM_EXC-1:0] exc_in,
  input logic [NUM_EXC-1:0] tfr
);
  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ack |=> int_req && $stable(int_vec));

  // R5
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && int_ack |=> !int_req);

  // R10
  exc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_in) |=> ((tfr & $past(exc_in)) == $past(exc_in)));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == FLAG_ADDR) |=> ((tfr & $past(tfr)) == $past(tfr)));
endmodule

bind prio_vector_intc intc_chk #(
  .NUM_EXC(NUM_EXC), .REG_AW(REG_AW), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .int_req  (int_req),
  .int_ack  (int_ack),
  .int_vec  (int_vec),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .exc_in   (exc_in),
  .tfr      (tfr_q)
);

// File: tb/tb_prio_vector_intc.sv
module tb_prio_vector_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 27;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NSRC-1:0] irq_strobe;
  logic [3:0]  cpu_prio;
  logic        reg_wr;
  logic [6:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        sw_trap_req;
  logic [6:0]  sw_trap_num;
  logic [3:0]  exc_in;
  logic        int_ack, int_req;
  logic [15:0] int_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vector_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_strobe(irq_strobe), .cpu_prio(cpu_prio),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sw_trap_req(sw_trap_req), .sw_trap_num(sw_trap_num), .exc_in(exc_in),
    .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic auto_ack = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: pops the scoreboard and acknowledges each grant.
  always @(negedge clk) begin
    if (auto_ack) begin
      if (int_ack) int_ack = 1'b0;
      else if (int_req) begin
        if (exp_q.size() == 0) check("unexpected grant (R3/R7)", int_vec, 32'hFFFF);
        else check(tag_q.pop_front(), int_vec, exp_q.pop_front());
        int_ack = 1'b1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      check("watchdog", 0, 1);
      summary();
    end
  end

  task automatic expect_vec(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 300 && exp_q.size() != 0; k++) @(negedge clk);
    if (exp_q.size() != 0) begin
      check("scoreboard drain", exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic strobe(input logic [NSRC-1:0] m);
    irq_strobe = m;
    @(negedge clk);
    irq_strobe = '0;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 20 && !int_req; k++) @(negedge clk);
  endtask

  logic [7:0] rv;

  initial begin
    rst_n = 1'b0; irq_strobe = '0; cpu_prio = '0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; sw_trap_req = 1'b0; sw_trap_num = '0; exc_in = '0; int_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    check("R13 int_req after reset", int_req, 0);
    rd(7'd0, rv);  check("R13 ctrl reg 0 after reset", rv, 8'h00);
    rd(7'h7F, rv); check("R13 flag reg after reset", rv, 8'h00);

    auto_ack = 1'b1;

    // R1 / R2 vector mapping for sources 0..3 and a high source
    wr(7'd0, 8'h45); wr(7'd1, 8'h45); wr(7'd2, 8'h45); wr(7'd3, 8'h45); wr(7'd10, 8'h45);
    rd(7'd0, rv); check("R1 ctrl readback", rv, 8'h45);
    expect_vec(16'h005C, "R2 source 0 vector"); strobe(27'h1); drain();
    expect_vec(16'h0084, "R2 source 1 vector"); strobe(27'h2); drain();
    expect_vec(16'h0080, "R2 source 2 vector"); strobe(27'h4); drain();
    expect_vec(16'h00A4, "R2 source 3 vector"); strobe(27'h8); drain();
    expect_vec(16'h00E8, "R2 source 10 vector"); strobe(27'h400); drain();

    // R4 highest priority first
    wr(7'd1, 8'h43); wr(7'd2, 8'h49);
    expect_vec(16'h0080, "R4 prio 9 first");
    expect_vec(16'h0084, "R4 prio 3 second");
    strobe(27'h6); drain();

    // R4 tie goes to lowest index
    wr(7'd1, 8'h47); wr(7'd3, 8'h47);
    expect_vec(16'h0084, "R4 tie lowest index");
    expect_vec(16'h00A4, "R4 tie higher index");
    strobe(27'hA); drain();

    // R3 strict priority compare
    wr(7'd0, 8'h44); cpu_prio = 4'd4;
    strobe(27'h1); repeat (5) @(negedge clk);
    check("R3 equal level blocked", int_req, 0);
    rd(7'd0, rv); check("R1 strobe sets pending", rv, 8'hC4);
    expect_vec(16'h005C, "R3 lower cpu level grants");
    cpu_prio = 4'd3; drain();
    cpu_prio = 4'd0;
    wr(7'd1, 8'h40); strobe(27'h2); repeat (5) @(negedge clk);
    check("R3 level 0 never requests", int_req, 0);
    wr(7'd1, 8'h00);

    // R7 disabled source
    wr(7'd2, 8'h0C); strobe(27'h4); repeat (5) @(negedge clk);
    check("R7 disabled no request", int_req, 0);
    rd(7'd2, rv); check("R7 pending recorded", rv, 8'h8C);

    // R8 software write clears and sets pending
    wr(7'd2, 8'h0C); rd(7'd2, rv); check("R8 write clears pending", rv, 8'h0C);
    expect_vec(16'h0080, "R8 write sets pending");
    wr(7'd2, 8'hCC); drain();

    // R9 software trap
    expect_vec(16'h0114, "R9 software trap vector");
    sw_trap_num = 7'h45; sw_trap_req = 1'b1; @(negedge clk); sw_trap_req = 1'b0;
    drain();

    // R10 / R11 exception trap and sticky flags
    expect_vec(16'h0028, "R10 exception common vector");
    exc_in = 4'h4; @(negedge clk); exc_in = 4'h0; drain();
    rd(7'h7F, rv); check("R11 flag survives acknowledge", rv, 8'h04);
    wr(7'h7F, 8'hFF); rd(7'h7F, rv); check("R11 write 1 keeps flag", rv, 8'h04);
    wr(7'h7F, 8'hFB); rd(7'h7F, rv); check("R11 write 0 clears flag", rv, 8'h00);

    // R12 precedence with all three arriving together
    wr(7'd0, 8'h4F);
    expect_vec(16'h0028, "R12 exception first");
    expect_vec(16'h0114, "R12 software trap second");
    expect_vec(16'h005C, "R12 peripheral last");
    exc_in = 4'h1; sw_trap_req = 1'b1; irq_strobe = 27'h1;
    @(negedge clk);
    exc_in = 4'h0; sw_trap_req = 1'b0; irq_strobe = '0;
    drain();
    wr(7'h7F, 8'h00);

    // R5 vector held until acknowledge
    auto_ack = 1'b0;
    wr(7'd1, 8'h45); strobe(27'h2); wait_req();
    check("R5 request raised", int_req, 1);
    wr(7'd0, 8'h4F); strobe(27'h1); cpu_prio = 4'd2;
    repeat (4) @(negedge clk);
    check("R5 vector stable", int_vec, 16'h0084);
    check("R5 request held", int_req, 1);
    int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    check("R5 ack drops request", int_req, 0);
    rd(7'd1, rv); check("R5 ack clears pending", rv, 8'h45);
    expect_vec(16'h005C, "R5 next grant after ack");
    auto_ack = 1'b1; drain();
    cpu_prio = 4'd0;

    // R6 strobe in the acknowledge cycle
    auto_ack = 1'b0;
    wr(7'd2, 8'h46); strobe(27'h4); wait_req();
    check("R6 first grant", int_vec, 16'h0080);
    int_ack = 1'b1; irq_strobe = 27'h4;
    @(negedge clk);
    int_ack = 1'b0; irq_strobe = '0;
    check("R6 request drops after ack", int_req, 0);
    rd(7'd2, rv); check("R6 strobe wins over ack", rv, 8'hC6);
    expect_vec(16'h0080, "R6 source granted again");
    auto_ack = 1'b1; drain();

    summary();
  end
endmodule